// File: doc/BRIEF.md
# USB Remote Wakeup Sequencer

This block times the resume signalling that a suspended USB function sends to wake its host. Software writes a request bit in a 16-bit control word. The block accepts the request only while the port is suspended and the host has allowed remote wakeup. It then keeps the bus idle for a short lead-in, drives the full-speed K state for a fixed length, and clears the request bit by itself. Software never has to time or end the pulse.

All timing is counted on a one-millisecond tick input. The lead-in and K length are parameters, with defaults of 2 ms and 10 ms. A USB bus reset clears only the request bit and releases the bus at once. The asynchronous power-on reset returns the whole block to its idle state.

Top module: `rwu_seq`

## Requirements
- R1: After power-on reset the read word is 0x0000 and the bus is released: line_oe_o = 0, dp_o = 0, dm_o = 0.
- R2: The wakeup request is bit 8 of the control word and reads back as 1 while a sequence is in progress. Bits 15:9 and 7:0 always read 0, whatever value was written to them.
- R3: A write with bit 8 = 1 is ignored when suspended_i = 0 or rwu_en_i = 0. Bit 8 stays 0 and the bus stays released.
- R4: After a write is accepted, line_oe_o stays 0 until LEAD_MS ticks have been counted. K drive begins in the cycle after the LEAD_MS-th tick.
- R5: While K is driven, line_oe_o = 1, dp_o = 0 and dm_o = 1, and this holds for K_MS ticks. Whenever line_oe_o = 0, both dp_o and dm_o are 0.
- R6: On the K_MS-th tick of the K phase, bit 8 clears to 0 and line_oe_o returns to 0 without any software write.
- R7: When bus_rst_i = 1, the sequence is aborted in the next cycle, during the lead-in or the K phase: bit 8 reads 0 and line_oe_o = 0. A write made in the same cycle as bus_rst_i is not accepted.
- R8: Writes made while a sequence is in progress are ignored, whether bit 8 is 0 or 1. The lead-in and K timing continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; must keep running while a request is pending |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| bus_rst_i | input | 1 | USB bus reset detected; clears the request only |
| suspended_i | input | 1 | Port is in the suspended state |
| rwu_en_i | input | 1 | Host has enabled remote wakeup |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read data |
| line_oe_o | output | 1 | Line driver output enable |
| dp_o | output | 1 | D+ drive value |
| dm_o | output | 1 | D- drive value |

## Verification
The assertions assume that tick_i is a single-cycle pulse with at least one idle cycle between pulses, and that the timing parameters are at least 1. Only under those conditions does each tick advance the phase counter by exactly one step. The bench produces ticks with a task that raises tick_i for one cycle and then holds it low for two cycles. It changes every input at the falling clock edge, so a write, a tick and a bus reset never overlap unless a scenario combines them on purpose. Suspend and enable are set before each request and are left unchanged while a sequence is running.

// File: rtl/rwu_pkg.sv
package rwu_pkg;
  localparam int unsigned WAKE_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_K    = 2'd2
  } rwu_state_e;
endpackage

// File: rtl/rwu_tick_cnt.sv
module rwu_tick_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == limit_i - CW'(1));
  assign done_o = tick_i & last & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (tick_i) begin
      if (last) cnt_q <= '0;
      else      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R4/R5: the phase counter never passes its limit
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);
endmodule

// File: rtl/rwu_ctrl.sv
module rwu_ctrl
  import rwu_pkg::*;
#(
  parameter int unsigned LEAD_MS = 2,
  parameter int unsigned K_MS    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bus_rst_i,
  input  logic tick_i,
  output logic busy_o,
  output logic k_o
);
  localparam int unsigned MAXMS = (LEAD_MS > K_MS) ? LEAD_MS : K_MS;
  localparam int unsigned CW    = $clog2(MAXMS + 1);

  rwu_state_e    state_q, state_d;
  logic          clr, done;
  logic [CW-1:0] limit;

  assign clr   = (state_q == ST_IDLE) | bus_rst_i;
  assign limit = (state_q == ST_K) ? CW'(K_MS) : CW'(LEAD_MS);

  rwu_tick_cnt #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (done)
  );

  always_comb begin
    state_d = state_q;
    if (bus_rst_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_d = ST_LEAD;
        ST_LEAD: if (done)    state_d = ST_K;
        ST_K:    if (done)    state_d = ST_IDLE;
        default:              state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);
  assign k_o    = (state_q == ST_K);

  // R4: K is entered only from the lead-in, on a tick
  a_r4_k_after_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(k_o) |-> ($past(state_q) == ST_LEAD) && $past(tick_i));
  // R5: K holds steady between ticks
  a_r5_k_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_o && !tick_i && !bus_rst_i) |=> k_o);
  // R7: bus reset forces idle
  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !busy_o);
endmodule

// File: rtl/rwu_seq.sv
module rwu_seq
  import rwu_pkg::*;
#(
  parameter int unsigned LEAD_MS = 2,
  parameter int unsigned K_MS    = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_rst_i,
  input  logic        suspended_i,
  input  logic        rwu_en_i,
  input  logic        tick_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        line_oe_o,
  output logic        dp_o,
  output logic        dm_o
);
  logic busy, k_on, start, req;

  assign req   = reg_we_i & reg_wdata_i[WAKE_BIT];
  assign start = req & suspended_i & rwu_en_i & ~bus_rst_i & ~busy;

  rwu_ctrl #(.LEAD_MS(LEAD_MS), .K_MS(K_MS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .bus_rst_i (bus_rst_i),
    .tick_i    (tick_i),
    .busy_o    (busy),
    .k_o       (k_on)
  );

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[WAKE_BIT] = busy;
  end

  // full-speed K: D+ low, D- high
  assign line_oe_o = k_on;
  assign dp_o      = 1'b0;
  assign dm_o      = k_on;

  // R2: accepted request reads back
  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && suspended_i && rwu_en_i && !bus_rst_i) |=> reg_rdata_o[WAKE_BIT]);
  // R3: request outside suspend/enable is dropped
  a_r3_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !(suspended_i && rwu_en_i) && !reg_rdata_o[WAKE_BIT])
      |=> !reg_rdata_o[WAKE_BIT]);
  // R8: writes during lead-in cannot end the sequence
  a_r8_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[WAKE_BIT] && !line_oe_o && reg_we_i && !bus_rst_i)
      |=> reg_rdata_o[WAKE_BIT]);
  // R7: bus released after bus reset
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !line_oe_o && !reg_rdata_o[WAKE_BIT]);
endmodule

// File: tb/rwu_seq_tb.sv
module rwu_seq_tb;
  localparam int unsigned LEAD = 2;
  localparam int unsigned KMS  = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_rst = 1'b0, susp = 1'b0, en = 1'b0, tick = 1'b0, we = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        oe, dp, dm;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  rwu_seq #(.LEAD_MS(LEAD), .K_MS(KMS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .suspended_i(susp),
    .rwu_en_i(en), .tick_i(tick), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .line_oe_o(oe), .dp_o(dp), .dm_o(dm)
  );

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {rdata, oe, dp, dm}
  function automatic logic [18:0] obs();
    return {rdata, oe, dp, dm};
  endfunction

  task automatic wr(input logic [15:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic brst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  localparam logic [18:0] IDLE_V = {16'h0000, 3'b000};
  localparam logic [18:0] LEAD_V = {16'h0100, 3'b000};
  localparam logic [18:0] K_V    = {16'h0100, 3'b101};

  task automatic t_reset();
    check("R1 reset", obs(), IDLE_V);
  endtask

  task automatic t_reject();
    susp = 1'b0; en = 1'b1; wr(16'h0100);
    check("R3 not suspended", obs(), IDLE_V);
    susp = 1'b1; en = 1'b0; wr(16'h0100);
    check("R3 not enabled", obs(), IDLE_V);
    pulse(); pulse(); pulse();
    check("R3 ticks no drive", obs(), IDLE_V);
  endtask

  task automatic t_full();
    susp = 1'b1; en = 1'b1; wr(16'hFFFF);
    check("R2 readback reserved zero", obs(), LEAD_V);
    for (int i = 1; i < LEAD; i++) begin
      pulse(); check("R4 lead-in", obs(), LEAD_V);
    end
    pulse(); check("R4/R5 K starts", obs(), K_V);
    for (int i = 1; i < KMS; i++) begin
      pulse(); check("R5 K held", obs(), K_V);
    end
    pulse(); check("R6 self clear", obs(), IDLE_V);
    pulse(); check("R6 stays idle", obs(), IDLE_V);
  endtask

  task automatic t_busy_write();
    wr(16'h0100);
    wr(16'h0000); check("R8 write 0 in lead", obs(), LEAD_V);
    pulse(); wr(16'h0100); check("R8 write 1 in lead", obs(), LEAD_V);
    pulse(); check("R8 K on time", obs(), K_V);
    wr(16'h0000); check("R8 write 0 in K", obs(), K_V);
    for (int i = 1; i < KMS; i++) pulse();
    check("R8 K length kept", obs(), K_V);
    pulse(); check("R6 clear after busy writes", obs(), IDLE_V);
  endtask

  task automatic t_bus_reset();
    wr(16'h0100);
    for (int i = 0; i < LEAD; i++) pulse();
    check("R7 pre K", obs(), K_V);
    brst(); check("R7 abort in K", obs(), IDLE_V);
    wr(16'h0100); pulse();
    brst(); check("R7 abort in lead", obs(), IDLE_V);
    pulse(); pulse(); check("R7 no drive after abort", obs(), IDLE_V);
    @(negedge clk); bus_rst = 1'b1; we = 1'b1; wdata = 16'h0100;
    @(negedge clk); bus_rst = 1'b0; we = 1'b0; wdata = '0;
    check("R7 write with bus reset", obs(), IDLE_V);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject();
    t_full();
    t_busy_write();
    t_bus_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule